// File: doc/BRIEF.md
# Floating-Point Exception Trap Arbiter

This block sits next to a floating-point coprocessor and decides, once for each finished instruction, whether a trap is raised and which one. When the instruction-complete strobe arrives, it takes the exception byte from the arithmetic datapath and the enable byte from the control register and ANDs them together. From the enabled exceptions that remain, it picks exactly one by a fixed priority.

The winning exception becomes a vector number. The block derives the table offset and the absolute handler address from that number and the vector base register. It also labels the report as mid-instruction when the finished instruction moved a data register to an external destination, and as pre-instruction for every other instruction. The trap request is a one-cycle pulse. The vector fields stay in place until the next strobe, so the processor side can read them at its own pace.

Top module: `fp_trap_arbiter`

## Requirements
- R1: When no bit of exc_i AND en_i is set at a strobe, trap_o stays low and vec_num_o, vec_off_o, vec_addr_o and mid_o are all zero after that strobe.
- R2: Each exception bit has a fixed vector number: bit 7 unordered branch/set gives 48, bit 6 signaling NaN gives 54, bit 5 operand error gives 52, bit 4 overflow gives 53, bit 3 underflow gives 51, bit 2 divide by zero gives 50, and bit 1 and bit 0 (the two inexact conditions) both give 49.
- R3: If several enabled exceptions are set, only the highest-numbered enabled bit (bit 7 highest, bit 0 lowest) selects the vector. A set bit that is not enabled never masks a lower enabled bit.
- R4: vec_off_o (10 bits) equals vec_num_o multiplied by 4.
- R5: vec_addr_o equals the vbase_i value sampled at the strobe plus vec_off_o, with the sum taken modulo 2^32.
- R6: mid_o is 1 after a trapping strobe that had move_out_i high. It is 0 after a trapping strobe with move_out_i low and after every strobe that does not trap.
- R7: trap_o goes high in the cycle after a strobe whose instruction has an enabled exception, and it stays high for exactly one cycle per strobe.
- R8: Without a strobe, changes on exc_i, en_i, vbase_i and move_out_i have no effect. The vector fields and mid_o hold their values until the next strobe.
- R9: A synchronous active-high reset clears trap_o, vec_num_o, vec_off_o, vec_addr_o and mid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| done_i | input | 1 | Instruction-complete strobe |
| exc_i | input | 8 | Exception status byte from the datapath |
| en_i | input | 8 | Exception enable byte from the control register |
| vbase_i | input | 32 | Vector base register |
| move_out_i | input | 1 | The finished instruction moved a data register to an external destination |
| trap_o | output | 1 | One-cycle trap request |
| vec_num_o | output | 8 | Selected vector number |
| vec_off_o | output | 10 | Vector table offset |
| vec_addr_o | output | 32 | Absolute vector address |
| mid_o | output | 1 | Report type: 1 for mid-instruction, 0 for pre-instruction |

## Verification
The hardest case to reach from the ports is one where a disabled higher-priority bit sits above an enabled lower bit. A wrong arbiter that picks from the raw exception byte would lose the trap or report the wrong vector, and it looks correct whenever the two bytes agree. The vector table therefore includes patterns that pair a set-but-disabled bit with an enabled lower bit, and patterns that set every bit while enabling only one. Directed steps cover the rest. One changes every input between strobes and checks that the held fields do not move. One holds the strobe high for two cycles in a row. One uses a base register near the top of the address space so the sum wraps.

// File: rtl/fp_trap_arbiter.sv
module fp_trap_arbiter #(
  parameter int ADDR_W = 32,
  parameter int NUM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [7:0]        exc_i,
  input  logic [7:0]        en_i,
  input  logic [ADDR_W-1:0] vbase_i,
  input  logic              move_out_i,
  output logic              trap_o,
  output logic [NUM_W-1:0]  vec_num_o,
  output logic [NUM_W+1:0]  vec_off_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              mid_o
);
  localparam int OFF_W = NUM_W + 2;

  logic [7:0]        hit;
  logic              any_hit;
  logic [NUM_W-1:0]  win_num;
  logic [OFF_W-1:0]  win_off;
  logic [ADDR_W-1:0] win_addr;

  assign hit     = exc_i & en_i;
  assign any_hit = |hit;

  always_comb begin
    casez (hit)
      8'b1???????: win_num = NUM_W'(48);
      8'b01??????: win_num = NUM_W'(54);
      8'b001?????: win_num = NUM_W'(52);
      8'b0001????: win_num = NUM_W'(53);
      8'b00001???: win_num = NUM_W'(51);
      8'b000001??: win_num = NUM_W'(50);
      8'b0000001?: win_num = NUM_W'(49);
      8'b00000001: win_num = NUM_W'(49);
      default:     win_num = '0;
    endcase
  end

  assign win_off  = {win_num, 2'b00};
  assign win_addr = vbase_i + ADDR_W'(win_off);

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o     <= 1'b0;
      vec_num_o  <= '0;
      vec_off_o  <= '0;
      vec_addr_o <= '0;
      mid_o      <= 1'b0;
    end else if (done_i) begin
      trap_o     <= any_hit;
      vec_num_o  <= win_num;
      vec_off_o  <= win_off;
      vec_addr_o <= any_hit ? win_addr : '0;
      mid_o      <= any_hit & move_out_i;
    end else begin
      trap_o     <= 1'b0;
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R7: a trap only follows a strobe
  a_r7_after_strobe: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> armed && $past(done_i));

  // R7: one pulse per strobe
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (trap_o && !done_i) |=> !trap_o);

  // R2
  a_r2_vec_range: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (vec_num_o >= NUM_W'(48) && vec_num_o <= NUM_W'(54)));

  // R1
  a_r1_quiet_zero: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(done_i) && !trap_o) |-> (vec_num_o == '0 && vec_addr_o == '0 && !mid_o));

  // R4
  a_r4_offset: assert property (@(posedge clk) disable iff (rst)
    vec_off_o == {vec_num_o, 2'b00});

  // R5
  a_r5_address: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> vec_addr_o == $past(vbase_i) + ADDR_W'(vec_off_o));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(done_i)) |-> ($stable(vec_num_o) && $stable(vec_addr_o) && $stable(mid_o)));

  // R6
  a_r6_mid_needs_trap: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(done_i) && mid_o) |-> trap_o);
endmodule

// File: tb/fp_trap_arbiter_test.sv
module fp_trap_arbiter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        done_i = 1'b0;
  logic [7:0]  exc_i = '0;
  logic [7:0]  en_i = '0;
  logic [31:0] vbase_i = '0;
  logic        move_out_i = 1'b0;
  logic        trap_o;
  logic [7:0]  vec_num_o;
  logic [9:0]  vec_off_o;
  logic [31:0] vec_addr_o;
  logic        mid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fp_trap_arbiter uut (
    .clk(clk), .rst(rst), .done_i(done_i), .exc_i(exc_i), .en_i(en_i),
    .vbase_i(vbase_i), .move_out_i(move_out_i), .trap_o(trap_o),
    .vec_num_o(vec_num_o), .vec_off_o(vec_off_o), .vec_addr_o(vec_addr_o),
    .mid_o(mid_o)
  );

  // {exc, en, move, base, exp_trap, exp_num}
  localparam int NV = 14;
  localparam logic [57:0] VEC [NV] = '{
    {8'h00, 8'hFF, 1'b0, 32'h0000_1000, 1'b0, 8'd0},
    {8'hFF, 8'h00, 1'b0, 32'h0000_1000, 1'b0, 8'd0},
    {8'h80, 8'h80, 1'b0, 32'h0000_2000, 1'b1, 8'd48},
    {8'h40, 8'h40, 1'b0, 32'h0000_2000, 1'b1, 8'd54},
    {8'h20, 8'h20, 1'b1, 32'h0000_3000, 1'b1, 8'd52},
    {8'h10, 8'h10, 1'b0, 32'h0000_3000, 1'b1, 8'd53},
    {8'h08, 8'h08, 1'b0, 32'h0001_0000, 1'b1, 8'd51},
    {8'h04, 8'h04, 1'b1, 32'h0001_0000, 1'b1, 8'd50},
    {8'h02, 8'h02, 1'b0, 32'h0000_0000, 1'b1, 8'd49},
    {8'h01, 8'h01, 1'b0, 32'h0000_0004, 1'b1, 8'd49},
    {8'hFF, 8'hFF, 1'b1, 32'h0000_0100, 1'b1, 8'd48},
    {8'hC4, 8'h7F, 1'b0, 32'h0000_0100, 1'b1, 8'd54},
    {8'hFF, 8'h04, 1'b0, 32'h1234_5600, 1'b1, 8'd50},
    {8'hF0, 8'h0F, 1'b1, 32'h0000_0100, 1'b0, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] e, input logic [7:0] n, input logic mv, input logic [31:0] b);
    @(negedge clk);
    exc_i = e; en_i = n; move_out_i = mv; vbase_i = b; done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic t, input logic [7:0] num,
                            input logic [31:0] b, input logic mv);
    logic [9:0] off;
    off = t ? {num, 2'b00} : 10'd0;
    chk({req, " trap"}, 32'(trap_o), 32'(t));
    chk({req, " num"},  32'(vec_num_o), 32'(num));
    chk({req, " off"},  32'(vec_off_o), 32'(off));
    chk({req, " addr"}, vec_addr_o, t ? b + 32'(off) : 32'd0);
    chk({req, " mid"},  32'(mid_o), 32'(t & mv));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    expect_out("R9 reset", 1'b0, 8'd0, 32'd0, 1'b0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 table
    for (int i = 0; i < NV; i++) begin
      logic [57:0] v;
      v = VEC[i];
      strobe(v[57:50], v[49:42], v[41], v[40:9]);
      expect_out("R1/R2/R3/R4/R5/R6 table", v[8], v[7:0], v[40:9], v[41]);
      @(negedge clk);
      chk("R7 pulse ends", 32'(trap_o), 32'd0);
    end

    // R5: address wraps
    strobe(8'h40, 8'hFF, 1'b0, 32'hFFFF_FFF0);
    chk("R5 wrap addr", vec_addr_o, 32'h0000_00C8);

    // R8: inputs change without strobe
    strobe(8'h10, 8'h10, 1'b1, 32'h0000_4000);
    @(negedge clk);
    exc_i = 8'hFF; en_i = 8'hFF; move_out_i = 1'b0; vbase_i = 32'h9999_0000;
    repeat (3) @(negedge clk);
    chk("R8 held trap", 32'(trap_o), 32'd0);
    chk("R8 held num", 32'(vec_num_o), 32'd53);
    chk("R8 held addr", vec_addr_o, 32'h0000_40D4);
    chk("R8 held mid", 32'(mid_o), 32'd1);

    // R7: back-to-back strobes, each gives its own result
    @(negedge clk);
    exc_i = 8'h08; en_i = 8'h08; move_out_i = 1'b0; vbase_i = 32'h0; done_i = 1'b1;
    @(negedge clk);
    chk("R7 first of pair trap", 32'(trap_o), 32'd1);
    chk("R7 first of pair num", 32'(vec_num_o), 32'd51);
    exc_i = 8'h00;
    @(negedge clk);
    done_i = 1'b0;
    chk("R7 second of pair trap", 32'(trap_o), 32'd0);
    chk("R1 second of pair num", 32'(vec_num_o), 32'd0);

    // R9: reset clears held trap fields
    strobe(8'h80, 8'h80, 1'b1, 32'h0000_0400);
    rst = 1'b1;
    @(negedge clk);
    expect_out("R9 reset after trap", 1'b0, 8'd0, 32'd0, 1'b0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule